// File: doc/BRIEF.md
# Dual-Core Mailbox Request/Response

This block passes commands and their replies between two processor cores. A master core places a command word and up to two follow-on address or data words in a request bank. A slave core answers by filling a response bank with a status/response-code word and a data word. Each core reaches all five 16-bit words through its own register port. The address map is the same on both ports.

Write rights are asymmetric. The master owns the request bank and the slave owns the response bank. A core that does not own a bank can read it, and it can do one other thing: it can clear that bank's valid flag. Each word 0 holds a valid flag in bit 5. A set flag drives a level interrupt to the other core. The usual exchange runs as follows. The master loads the follow-on words and then writes the command with bit 5 set. The slave takes the request and clears that flag. It then writes its data and writes a code word with bit 5 set, for example 0x0022, which gives code 0x02 and sets the flag in one write. The master reads the response and clears the flag. Every register returns to 0000h on reset.

Top module: `dual_core_mailbox`

## Requirements
- R1: After reset, all five words read 0x0000 on both ports, and both interrupts are low.
- R2: The address map is: request words 0, 1 and 2 at addresses 0, 1 and 2; response words 0 and 1 at addresses 3 and 4. A master write to addresses 0–2 stores the full 16-bit value. Both ports read it back combinationally from the following cycle.
- R3: Slave writes to addresses 1 and 2 are ignored. A slave write to address 0 with bit 5 = 1 is ignored.
- R4: Slave writes to addresses 3 and 4 store the full value. Master writes to address 4 are ignored. A master write to address 3 with bit 5 = 1 is ignored.
- R5: A single slave write of 0x0022 to address 3 stores response code 0x02 in the low bits and sets the response-valid flag (bit 5). m_irq_o is high from the next cycle.
- R6: A master write to address 3 with bit 5 = 0 clears only the response-valid flag. The other bits keep their value, and m_irq_o falls in the next cycle.
- R7: Bit 5 of request word 0 is the request-valid flag and drives s_irq_o. A slave write to address 0 with bit 5 = 0 clears only that flag.
- R8: Suppose the owner sets a flag and the reading core clears it in the same cycle. The flag ends cleared, and the owner's other bits of word 0 are still stored.
- R9: Addresses 5–7 read 0x0000 on both ports, and writes to them have no effect.
- R10: Each interrupt is a level. It stays high on idle cycles and on unrelated writes until its flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_we_i | input | 1 | Master write strobe |
| m_addr_i | input | 3 | Master word address |
| m_wdata_i | input | 16 | Master write data |
| m_rdata_o | output | 16 | Master read data for m_addr_i |
| m_irq_o | output | 1 | Response pending, to master |
| s_we_i | input | 1 | Slave write strobe |
| s_addr_i | input | 3 | Slave word address |
| s_wdata_i | input | 16 | Slave write data |
| s_rdata_o | output | 16 | Slave read data for s_addr_i |
| s_irq_o | output | 1 | Request pending, to slave |

## Verification
The bench targets the same-cycle collision in which the owner sets a flag while the reader clears it. A design that lets the set win would leave a stale interrupt raised, and the handshake would repeat. The bench also targets a reader's clear write. A design that stored the whole word on that write would wipe the command or response code. Reader writes with bit 5 set must leave the word untouched. Writes to the unused addresses and to the words a core does not own are checked as well, because a wrong decode there corrupts the other core's data without any sign.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 3;
  localparam int REQ_WORDS = 3;
  localparam int RSP_WORDS = 2;
  localparam int VALID_BIT = 5;
  localparam int RSP_BASE  = REQ_WORDS;
endpackage

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int DW     = 16,
  parameter int NWORDS = 3,
  parameter int VB     = 5,
  localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 clr_i,
  output logic [NWORDS*DW-1:0] words_o,
  output logic                 valid_o
);
  logic [DW-1:0] word_q [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IW'(i));
    if (i == 0) begin : g_flag
      // reader clear beats owner set
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          word_q[i] <= '0;
        end else begin
          if (hit) word_q[i] <= wr_data_i;
          if (clr_i) word_q[i][VB] <= 1'b0;
        end
      end
    end else begin : g_data
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  word_q[i] <= '0;
        else if (hit) word_q[i] <= wr_data_i;
      end
    end
    assign words_o[i*DW +: DW] = word_q[i];
  end

  assign valid_o = word_q[0][VB];
endmodule

// File: rtl/mbox_rd_mux.sv
module mbox_rd_mux #(
  parameter int DW        = 16,
  parameter int AW        = 3,
  parameter int REQ_WORDS = 3,
  parameter int RSP_WORDS = 2
) (
  input  logic [AW-1:0]           addr_i,
  input  logic [REQ_WORDS*DW-1:0] req_words_i,
  input  logic [RSP_WORDS*DW-1:0] rsp_words_i,
  output logic [DW-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < REQ_WORDS; i++)
      if (addr_i == AW'(i)) rdata_o = req_words_i[i*DW +: DW];
    for (int j = 0; j < RSP_WORDS; j++)
      if (addr_i == AW'(REQ_WORDS + j)) rdata_o = rsp_words_i[j*DW +: DW];
  end
endmodule

// File: rtl/dual_core_mailbox.sv
module dual_core_mailbox
  import mbox_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          m_we_i,
  input  logic [AW-1:0] m_addr_i,
  input  logic [DW-1:0] m_wdata_i,
  output logic [DW-1:0] m_rdata_o,
  output logic          m_irq_o,
  input  logic          s_we_i,
  input  logic [AW-1:0] s_addr_i,
  input  logic [DW-1:0] s_wdata_i,
  output logic [DW-1:0] s_rdata_o,
  output logic          s_irq_o
);
  localparam int REQ_IW = (REQ_WORDS > 1) ? $clog2(REQ_WORDS) : 1;
  localparam int RSP_IW = (RSP_WORDS > 1) ? $clog2(RSP_WORDS) : 1;
  localparam logic [AW-1:0] REQ_END_A  = AW'(REQ_WORDS);
  localparam logic [AW-1:0] RSP_BASE_A = AW'(RSP_BASE);
  localparam logic [AW-1:0] RSP_END_A  = AW'(RSP_BASE + RSP_WORDS);

  logic [REQ_WORDS*DW-1:0] req_words;
  logic [RSP_WORDS*DW-1:0] rsp_words;
  logic                    req_valid, rsp_valid;

  logic              m_req_wr, s_rsp_wr, s_req_clr, m_rsp_clr;
  logic [REQ_IW-1:0] m_req_idx;
  logic [RSP_IW-1:0] s_rsp_idx;

  // owner writes
  assign m_req_wr  = m_we_i && (m_addr_i < REQ_END_A);
  assign m_req_idx = REQ_IW'(m_addr_i);
  assign s_rsp_wr  = s_we_i && (s_addr_i >= RSP_BASE_A) && (s_addr_i < RSP_END_A);
  assign s_rsp_idx = RSP_IW'(s_addr_i - RSP_BASE_A);

  // reader may only clear the flag in word 0
  assign s_req_clr = s_we_i && (s_addr_i == '0) && !s_wdata_i[VALID_BIT];
  assign m_rsp_clr = m_we_i && (m_addr_i == RSP_BASE_A) && !m_wdata_i[VALID_BIT];

  mbox_bank #(.DW(DW), .NWORDS(REQ_WORDS), .VB(VALID_BIT)) u_req_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (m_req_wr),
    .wr_idx_i (m_req_idx),
    .wr_data_i(m_wdata_i),
    .clr_i    (s_req_clr),
    .words_o  (req_words),
    .valid_o  (req_valid)
  );

  mbox_bank #(.DW(DW), .NWORDS(RSP_WORDS), .VB(VALID_BIT)) u_rsp_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (s_rsp_wr),
    .wr_idx_i (s_rsp_idx),
    .wr_data_i(s_wdata_i),
    .clr_i    (m_rsp_clr),
    .words_o  (rsp_words),
    .valid_o  (rsp_valid)
  );

  mbox_rd_mux #(.DW(DW), .AW(AW), .REQ_WORDS(REQ_WORDS), .RSP_WORDS(RSP_WORDS)) u_m_rd (
    .addr_i     (m_addr_i),
    .req_words_i(req_words),
    .rsp_words_i(rsp_words),
    .rdata_o    (m_rdata_o)
  );

  mbox_rd_mux #(.DW(DW), .AW(AW), .REQ_WORDS(REQ_WORDS), .RSP_WORDS(RSP_WORDS)) u_s_rd (
    .addr_i     (s_addr_i),
    .req_words_i(req_words),
    .rsp_words_i(rsp_words),
    .rdata_o    (s_rdata_o)
  );

  assign s_irq_o = req_valid;
  assign m_irq_o = rsp_valid;
endmodule

// File: rtl/dual_core_mailbox_chk.sv
module dual_core_mailbox_chk
  import mbox_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                m_we_i,
  input logic [ADDR_W-1:0]   m_addr_i,
  input logic [DATA_W-1:0]   m_wdata_i,
  input logic [DATA_W-1:0]   m_rdata_o,
  input logic                m_irq_o,
  input logic                s_we_i,
  input logic [ADDR_W-1:0]   s_addr_i,
  input logic [DATA_W-1:0]   s_wdata_i,
  input logic [DATA_W-1:0]   s_rdata_o,
  input logic                s_irq_o
);
  logic m_set_req, s_clr_req, s_set_rsp, m_clr_rsp, m_clr_req_own, s_clr_rsp_own;
  assign m_set_req     = m_we_i && m_addr_i == 3'd0 && m_wdata_i[VALID_BIT];
  assign m_clr_req_own = m_we_i && m_addr_i == 3'd0 && !m_wdata_i[VALID_BIT];
  assign s_clr_req     = s_we_i && s_addr_i == 3'd0 && !s_wdata_i[VALID_BIT];
  assign s_set_rsp     = s_we_i && s_addr_i == 3'd3 && s_wdata_i[VALID_BIT];
  assign s_clr_rsp_own = s_we_i && s_addr_i == 3'd3 && !s_wdata_i[VALID_BIT];
  assign m_clr_rsp     = m_we_i && m_addr_i == 3'd3 && !m_wdata_i[VALID_BIT];

  assert_req_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_set_req && !s_clr_req) |=> s_irq_o);
  assert_req_clr_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_clr_req |=> !s_irq_o);
  assert_rsp_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_set_rsp && !m_clr_rsp) |=> m_irq_o);
  assert_rsp_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_clr_rsp |=> !m_irq_o);
  assert_req_irq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_irq_o && !s_clr_req && !m_clr_req_own) |=> s_irq_o);
  assert_rsp_irq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_irq_o && !m_clr_rsp && !s_clr_rsp_own) |=> m_irq_o);
  assert_hole_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_addr_i > 3'd4) |-> (m_rdata_o == '0));
  assert_slave_req1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_addr_i == 3'd1 && !(m_we_i && m_addr_i == 3'd1)) |=> $stable(s_rdata_o) || s_addr_i != 3'd1);
endmodule

bind dual_core_mailbox dual_core_mailbox_chk u_chk (.*);

// File: tb/dual_core_mailbox_test.sv
`timescale 1ns/1ps
module dual_core_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_we, s_we;
  logic [2:0]  m_addr, s_addr;
  logic [15:0] m_wdata, s_wdata, m_rdata, s_rdata;
  logic        m_irq, s_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [15:0] req_m [3];
  logic [15:0] rsp_m [2];

  always #4 clk = ~clk;

  dual_core_mailbox uut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_we_i(m_we), .m_addr_i(m_addr), .m_wdata_i(m_wdata), .m_rdata_o(m_rdata), .m_irq_o(m_irq),
    .s_we_i(s_we), .s_addr_i(s_addr), .s_wdata_i(s_wdata), .s_rdata_o(s_rdata), .s_irq_o(s_irq)
  );

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return req_m[0];
      3'd1: return req_m[1];
      3'd2: return req_m[2];
      3'd3: return rsp_m[0];
      3'd4: return rsp_m[1];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model: owner writes first, then reader clears (clear wins)
  task automatic model(input logic mwe, input logic [2:0] ma, input logic [15:0] mwd,
                       input logic swe, input logic [2:0] sa, input logic [15:0] swd);
    if (mwe && ma < 3'd3) req_m[ma] = mwd;
    if (swe && (sa == 3'd3 || sa == 3'd4)) rsp_m[sa - 3'd3] = swd;
    if (swe && sa == 3'd0 && !swd[5]) req_m[0][5] = 1'b0;
    if (mwe && ma == 3'd3 && !mwd[5]) rsp_m[0][5] = 1'b0;
  endtask

  task automatic step(input logic mwe, input logic [2:0] ma, input logic [15:0] mwd,
                      input logic swe, input logic [2:0] sa, input logic [15:0] swd);
    @(negedge clk);
    m_we = mwe; m_addr = ma; m_wdata = mwd;
    s_we = swe; s_addr = sa; s_wdata = swd;
    @(posedge clk);
    model(mwe, ma, mwd, swe, sa, swd);
    @(negedge clk);
    m_we = 1'b0; s_we = 1'b0;
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      m_addr = 3'(a); s_addr = 3'(7 - a);
      #1;
      check(m_rdata, exp_rd(3'(a)), tag);
      check(s_rdata, exp_rd(3'(7 - a)), tag);
    end
    check({15'd0, s_irq}, {15'd0, req_m[0][5]}, {tag, " s_irq"});
    check({15'd0, m_irq}, {15'd0, rsp_m[0][5]}, {tag, " m_irq"});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    m_we = 0; s_we = 0; m_addr = 0; s_addr = 0; m_wdata = 0; s_wdata = 0;
    foreach (req_m[i]) req_m[i] = 16'h0;
    foreach (rsp_m[i]) rsp_m[i] = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all("R1 reset");

    // R2, R7: master fills request, valid set
    step(1, 3'd1, 16'hBEEF, 0, 0, 0);
    step(1, 3'd2, 16'h1234, 0, 0, 0);
    step(1, 3'd0, 16'h0025, 0, 0, 0);
    check_all("R2 R7 request load");

    // R3: slave writes to request words ignored
    step(0, 0, 0, 1, 3'd1, 16'hFFFF);
    step(0, 0, 0, 1, 3'd2, 16'hFFFF);
    step(0, 0, 0, 1, 3'd0, 16'hFFFF);
    check_all("R3 slave req writes");

    // R7: slave clears request flag only
    step(0, 0, 0, 1, 3'd0, 16'h0000);
    check_all("R7 req clear");

    // R5: response data and 0x22 code word
    step(0, 0, 0, 1, 3'd4, 16'hCAFE);
    step(0, 0, 0, 1, 3'd3, 16'h0022);
    check_all("R5 response");

    // R4: master writes to response ignored, R10 irq holds
    step(1, 3'd4, 16'h0000, 0, 0, 0);
    step(1, 3'd3, 16'hFFFF, 0, 0, 0);
    check_all("R4 master rsp writes");
    repeat (5) @(negedge clk);
    step(1, 3'd1, 16'h5555, 0, 0, 0);
    check_all("R10 level hold");

    // R6: master clears response flag only
    step(1, 3'd3, 16'h0000, 0, 0, 0);
    check_all("R6 rsp clear");

    // R8: same-cycle set and clear on both flags
    step(1, 3'd0, 16'h003F, 1, 3'd0, 16'h0000);
    check_all("R8 req collision");
    step(1, 3'd3, 16'h0000, 1, 3'd3, 16'h0021);
    check_all("R8 rsp collision");

    // R9: unmapped addresses
    for (int a = 5; a < 8; a++) step(1, 3'(a), 16'hFFFF, 1, 3'(a), 16'hFFFF);
    check_all("R9 holes");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] mw, sw;
      mw = 16'($urandom); sw = 16'($urandom);
      step(1'($urandom), 3'($urandom), mw, 1'($urandom), 3'($urandom), sw);
      check_all("R2 R8 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule